// File: doc/BRIEF.md
# Multithreaded Windowed Register File

This block holds the integer register state of every hardware thread of a fine-grain multithreaded pipeline in one shared RAM array. Each thread owns a fixed slice of 64 words. The slice holds the eight globals, the trap base word, seven scratch words reserved for microcode, and three physical register windows of sixteen words each. The block turns a register request into a physical word address by placing the thread number above a 6-bit slice index. The slice index comes from the register number and the current window pointer.

Each core cycle the block serves one write and two reads. It does this by clocking the storage at twice the core rate. A two-state phase machine runs the storage. In state `PH_WR` (the first half of a core cycle) it captures the requests and commits the write. In state `PH_RD` (the second half) it reads both operands. The transitions are `PH_WR -> PH_RD` and `PH_RD -> PH_WR` on every fast-clock edge, and reset enters `PH_WR`. Every word carries an even-parity bit. A read whose word fails the parity check raises a soft-error flag. Requests that cannot be mapped are flagged and have no effect. Generating window traps is left to the pipeline.

Top module: `mtrf_regfile`

## Requirements
- R1: The physical address is {thread number, 6-bit slice index}. A write made for one thread is never returned by a read for a different thread.
- R2: Kind code 0 with register numbers 1 to 7 selects the globals at slice 1 to 7. The same word is reached from every window pointer value, including pointers that R7 rejects.
- R3: Register 0 with kind 0 reads as zero, with no parity or fault flag. A write to it is discarded without a reject.
- R4: Kind code 1 selects the trap base word at slice 8. The register number is ignored and no microcode mode is needed.
- R5: Kind code 2 with numbers 1 to 7 selects scratch words at slice 9 to 15, and only while the port's microcode input is high. Outside microcode mode a read returns zero with the fault flag set. A write is dropped, and `wr_reject` rises for that core cycle.
- R6: For registers 8 to 31 the physical window is w = pointer mod 3. Locals (16 to 23) sit at slice 16+16w+0..7 and ins (24 to 31) at 16+16w+8..15. Outs (8 to 15) share the ins of window (w+2) mod 3, which is (w-1) mod 3.
- R7: A window pointer at or above CWP_LIMIT (default 6) on registers 8 to 31 faults. The read returns zero, and a write is rejected and leaves storage unchanged.
- R8: Kind code 3, and kind 2 with number 0 or above 7, fault on read and are rejected on write.
- R9: Requests are sampled at the first fast edge after a core-cycle boundary, and the write commits on that edge. Read results change only on the second fast edge and then hold for a full core cycle. A read of the word being written in the same core cycle returns the new data.
- R10: Each word stores even parity, and `wr_flip_par` inverts the stored bit. A read of a word with bad parity sets that port's `rd_perr` while still returning the data. Rewriting the word with the flip low clears the error.
- R11: After reset, both read data outputs and all flags are zero, and the phase machine is in `PH_WR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Storage clock, twice the core rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this core cycle |
| wr_tid | input | TID_W | Thread of the write |
| wr_cwp | input | CWP_W | Window pointer of the writing thread |
| wr_ucode | input | 1 | Writer is in microcode mode |
| wr_kind | input | 2 | Write target kind: 0 integer, 1 trap base, 2 scratch, 3 reserved |
| wr_idx | input | 5 | Register or scratch number of the write |
| wr_data | input | DATA_W | Write data |
| wr_flip_par | input | 1 | Store an inverted parity bit (soft-error injection) |
| rd_tid | input | TID_W | Thread of both reads |
| rd_cwp | input | CWP_W | Window pointer of the reading thread |
| rd_ucode | input | 1 | Reader is in microcode mode |
| rd_kind_a | input | 2 | Kind for read port A |
| rd_idx_a | input | 5 | Number for read port A |
| rd_kind_b | input | 2 | Kind for read port B |
| rd_idx_b | input | 5 | Number for read port B |
| rd_data_a | output | DATA_W | Read data A |
| rd_perr_a | output | 1 | Parity error on read A |
| rd_fault_a | output | 1 | Read A could not be mapped |
| rd_data_b | output | DATA_W | Read data B |
| rd_perr_b | output | 1 | Parity error on read B |
| rd_fault_b | output | 1 | Read B could not be mapped |
| wr_reject | output | 1 | The write of this core cycle was refused |

## Verification
A wrong slice index or window rotation shows up on the next read of the aliased register. There the data of another window, thread or global appears instead of the value the bench wrote, one core cycle after the read is issued. A phase machine stuck in one state either never commits writes or never refreshes read data, so the following read already mismatches. A missing write-first ordering shows up as stale data on the same-cycle read. A wrongly computed parity bit raises the soft-error flag on the first read of any written word.

// File: rtl/mtrf_pkg.sv
package mtrf_pkg;

    typedef enum logic [1:0] {
        KIND_ARCH = 2'd0,
        KIND_TBR  = 2'd1,
        KIND_SCR  = 2'd2,
        KIND_RSVD = 2'd3
    } reg_kind_e;

    typedef enum logic {
        PH_WR = 1'b0,
        PH_RD = 1'b1
    } phase_e;

    localparam int LOCAL_W  = 6;
    localparam int GLOB_N   = 8;
    localparam int TBR_SLOT = 8;
    localparam int WIN_BASE = 16;
    localparam int WIN_SPAN = 16;
    localparam int NWIN     = 3;

endpackage

// File: rtl/mtrf_win_map.sv
module mtrf_win_map
    import mtrf_pkg::*;
#(
    parameter int TID_W     = 3,
    parameter int CWP_W     = 3,
    parameter int CWP_LIMIT = 6
) (
    input  logic [TID_W-1:0]         tid,
    input  logic [CWP_W-1:0]         cwp,
    input  logic                     ucode,
    input  logic [1:0]               kind,
    input  logic [4:0]               idx,
    output logic [TID_W+LOCAL_W-1:0] addr,
    output logic                     fault,
    output logic                     zero
);

    localparam logic [CWP_W:0] LIM = (CWP_W+1)'(CWP_LIMIT);

    reg_kind_e          k;
    logic [1:0]         win;
    logic [1:0]         out_win;
    logic [LOCAL_W-1:0] own_base;
    logic [LOCAL_W-1:0] out_base;
    logic [LOCAL_W-1:0] slot;
    logic [LOCAL_W-1:0] low3;

    always_comb begin
        k        = reg_kind_e'(kind);
        win      = 2'(cwp % NWIN);
        out_win  = (win == 2'd0) ? 2'(NWIN - 1) : win - 2'd1;
        own_base = LOCAL_W'(WIN_BASE) + {win, 4'b0000};
        out_base = LOCAL_W'(WIN_BASE) + {out_win, 4'b0000};
        low3     = {3'b000, idx[2:0]};
        slot     = '0;
        fault    = 1'b0;
        zero     = 1'b0;
        unique case (k)
            KIND_ARCH: begin
                if (idx < 5'(GLOB_N)) begin
                    slot = {1'b0, idx};
                    zero = (idx == 5'd0);
                end else if ({1'b0, cwp} >= LIM) begin
                    fault = 1'b1;
                end else if (idx < 5'd16) begin
                    slot = out_base + 6'd8 + low3;
                end else if (idx < 5'd24) begin
                    slot = own_base + low3;
                end else begin
                    slot = own_base + 6'd8 + low3;
                end
            end
            KIND_TBR: begin
                slot = LOCAL_W'(TBR_SLOT);
            end
            KIND_SCR: begin
                if (!ucode || idx == 5'd0 || idx > 5'd7) begin
                    fault = 1'b1;
                end else begin
                    slot = LOCAL_W'(TBR_SLOT) + low3;
                end
            end
            KIND_RSVD: begin
                fault = 1'b1;
            end
        endcase
        addr = {tid, slot};
    end

endmodule

// File: rtl/mtrf_par_store.sv
module mtrf_par_store #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wflip,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    output logic              rperr_a,
    output logic              rperr_b
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int WORD_W = DATA_W + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] word_a;
    logic [WORD_W-1:0] word_b;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {(^wdata) ^ wflip, wdata};
        end
        if (re) begin
            word_a <= mem[raddr_a];
            word_b <= mem[raddr_b];
        end
    end

    assign rdata_a = word_a[DATA_W-1:0];
    assign rdata_b = word_b[DATA_W-1:0];
    assign rperr_a = ^word_a;
    assign rperr_b = ^word_b;

endmodule

// File: rtl/mtrf_regfile.sv
module mtrf_regfile
    import mtrf_pkg::*;
#(
    parameter int THREADS   = 8,
    parameter int DATA_W    = 32,
    parameter int CWP_W     = 3,
    parameter int CWP_LIMIT = 6,
    localparam int TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_tid,
    input  logic [CWP_W-1:0]  wr_cwp,
    input  logic              wr_ucode,
    input  logic [1:0]        wr_kind,
    input  logic [4:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_flip_par,
    input  logic [TID_W-1:0]  rd_tid,
    input  logic [CWP_W-1:0]  rd_cwp,
    input  logic              rd_ucode,
    input  logic [1:0]        rd_kind_a,
    input  logic [4:0]        rd_idx_a,
    input  logic [1:0]        rd_kind_b,
    input  logic [4:0]        rd_idx_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic              rd_perr_a,
    output logic              rd_fault_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              rd_perr_b,
    output logic              rd_fault_b,
    output logic              wr_reject
);

    localparam int ADDR_W = TID_W + LOCAL_W;
    localparam int NPORT  = 3;   // 0 write, 1 read A, 2 read B

    phase_e ph;
    phase_e ph_nxt;

    logic [TID_W-1:0]  m_tid   [NPORT];
    logic [CWP_W-1:0]  m_cwp   [NPORT];
    logic              m_ucode [NPORT];
    logic [1:0]        m_kind  [NPORT];
    logic [4:0]        m_idx   [NPORT];
    logic [ADDR_W-1:0] m_addr  [NPORT];
    logic              m_fault [NPORT];
    logic              m_zero  [NPORT];

    assign m_tid[0]   = wr_tid;
    assign m_cwp[0]   = wr_cwp;
    assign m_ucode[0] = wr_ucode;
    assign m_kind[0]  = wr_kind;
    assign m_idx[0]   = wr_idx;
    assign m_tid[1]   = rd_tid;
    assign m_cwp[1]   = rd_cwp;
    assign m_ucode[1] = rd_ucode;
    assign m_kind[1]  = rd_kind_a;
    assign m_idx[1]   = rd_idx_a;
    assign m_tid[2]   = rd_tid;
    assign m_cwp[2]   = rd_cwp;
    assign m_ucode[2] = rd_ucode;
    assign m_kind[2]  = rd_kind_b;
    assign m_idx[2]   = rd_idx_b;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        mtrf_win_map #(
            .TID_W    (TID_W),
            .CWP_W    (CWP_W),
            .CWP_LIMIT(CWP_LIMIT)
        ) u_map (
            .tid  (m_tid[p]),
            .cwp  (m_cwp[p]),
            .ucode(m_ucode[p]),
            .kind (m_kind[p]),
            .idx  (m_idx[p]),
            .addr (m_addr[p]),
            .fault(m_fault[p]),
            .zero (m_zero[p])
        );
    end

    // phase state register
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) ph <= PH_WR;
        else        ph <= ph_nxt;
    end

    always_comb begin
        unique case (ph)
            PH_WR: ph_nxt = PH_RD;
            PH_RD: ph_nxt = PH_WR;
        endcase
    end

    // captured read requests and output flags
    logic [ADDR_W-1:0] cap_addr_a, cap_addr_b;
    logic              cap_fault_a, cap_fault_b;
    logic              cap_kill_a, cap_kill_b;
    logic              kill_a, kill_b;

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr_a  <= '0;
            cap_addr_b  <= '0;
            cap_fault_a <= 1'b0;
            cap_fault_b <= 1'b0;
            cap_kill_a  <= 1'b1;
            cap_kill_b  <= 1'b1;
            kill_a      <= 1'b1;
            kill_b      <= 1'b1;
            rd_fault_a  <= 1'b0;
            rd_fault_b  <= 1'b0;
            wr_reject   <= 1'b0;
        end else begin
            unique case (ph)
                PH_WR: begin
                    cap_addr_a  <= m_addr[1];
                    cap_addr_b  <= m_addr[2];
                    cap_fault_a <= m_fault[1];
                    cap_fault_b <= m_fault[2];
                    cap_kill_a  <= m_fault[1] | m_zero[1];
                    cap_kill_b  <= m_fault[2] | m_zero[2];
                    wr_reject   <= wr_en & m_fault[0];
                end
                PH_RD: begin
                    kill_a     <= cap_kill_a;
                    kill_b     <= cap_kill_b;
                    rd_fault_a <= cap_fault_a;
                    rd_fault_b <= cap_fault_b;
                end
            endcase
        end
    end

    logic              st_we;
    logic              st_re;
    logic [DATA_W-1:0] st_data_a, st_data_b;
    logic              st_perr_a, st_perr_b;

    assign st_we = (ph == PH_WR) && wr_en && !m_fault[0] && !m_zero[0];
    assign st_re = (ph == PH_RD);

    mtrf_par_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk    (clk2x),
        .we     (st_we),
        .waddr  (m_addr[0]),
        .wdata  (wr_data),
        .wflip  (wr_flip_par),
        .re     (st_re),
        .raddr_a(cap_addr_a),
        .raddr_b(cap_addr_b),
        .rdata_a(st_data_a),
        .rdata_b(st_data_b),
        .rperr_a(st_perr_a),
        .rperr_b(st_perr_b)
    );

    assign rd_data_a = kill_a ? '0 : st_data_a;
    assign rd_data_b = kill_b ? '0 : st_data_b;
    assign rd_perr_a = !kill_a && st_perr_a;
    assign rd_perr_b = !kill_b && st_perr_b;

    // ---------------- assertions ----------------
    p_phase_wr_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
        (ph == PH_WR) |=> (ph == PH_RD));

    p_phase_rd_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
        (ph == PH_RD) |=> (ph == PH_WR));

    // read results only move on the read-half edge
    p_hold_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
        (ph == PH_RD) |-> ($stable(rd_data_a) && $stable(rd_data_b)));

    p_fault_quiet_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
        rd_fault_a |-> (rd_data_a == '0 && !rd_perr_a));

    p_fault_quiet_b_r8: assert property (@(posedge clk2x) disable iff (!rst_n)
        rd_fault_b |-> (rd_data_b == '0 && !rd_perr_b));

    p_g0_unwritten_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
        st_we |-> (m_addr[0][LOCAL_W-1:0] != '0));

    p_scratch_guard_r5: assert property (@(posedge clk2x) disable iff (!rst_n)
        (st_we && m_addr[0][LOCAL_W-1:3] == 3'b001 && m_addr[0][2:0] != 3'b000)
            |-> wr_ucode);

    p_reject_no_store_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
        (ph == PH_RD && wr_reject) |-> !$past(st_we));

endmodule

// File: tb/mtrf_regfile_bench.sv
`timescale 1ns/1ps
module mtrf_regfile_bench;

    localparam int THREADS = 8;
    localparam int DW      = 32;
    localparam int CW      = 3;
    localparam int TW      = 3;
    localparam logic [1:0] KA = 2'd0, KT = 2'd1, KS = 2'd2, KR = 2'd3;

    logic          clk2x = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [TW-1:0] wr_tid = '0;
    logic [CW-1:0] wr_cwp = '0;
    logic          wr_ucode = 1'b0;
    logic [1:0]    wr_kind = KA;
    logic [4:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_flip_par = 1'b0;
    logic [TW-1:0] rd_tid = '0;
    logic [CW-1:0] rd_cwp = '0;
    logic          rd_ucode = 1'b0;
    logic [1:0]    rd_kind_a = KA;
    logic [4:0]    rd_idx_a = '0;
    logic [1:0]    rd_kind_b = KA;
    logic [4:0]    rd_idx_b = '0;
    logic [DW-1:0] rd_data_a, rd_data_b;
    logic          rd_perr_a, rd_perr_b, rd_fault_a, rd_fault_b, wr_reject;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk2x = ~clk2x;

    mtrf_regfile #(.THREADS(THREADS), .DATA_W(DW), .CWP_W(CW), .CWP_LIMIT(6)) u_mtrf_regfile (
        .clk2x(clk2x), .rst_n(rst_n),
        .wr_en(wr_en), .wr_tid(wr_tid), .wr_cwp(wr_cwp), .wr_ucode(wr_ucode),
        .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data), .wr_flip_par(wr_flip_par),
        .rd_tid(rd_tid), .rd_cwp(rd_cwp), .rd_ucode(rd_ucode),
        .rd_kind_a(rd_kind_a), .rd_idx_a(rd_idx_a), .rd_kind_b(rd_kind_b), .rd_idx_b(rd_idx_b),
        .rd_data_a(rd_data_a), .rd_perr_a(rd_perr_a), .rd_fault_a(rd_fault_a),
        .rd_data_b(rd_data_b), .rd_perr_b(rd_perr_b), .rd_fault_b(rd_fault_b),
        .wr_reject(wr_reject)
    );

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one core cycle: sample edge, read edge, then settle
    task automatic cyc();
        @(posedge clk2x);
        @(posedge clk2x);
        #1;
    endtask

    task automatic set_wr(input logic [TW-1:0] t, input logic [CW-1:0] c, input logic u,
                          input logic [1:0] k, input logic [4:0] i, input logic [DW-1:0] d,
                          input logic f);
        wr_en = 1'b1; wr_tid = t; wr_cwp = c; wr_ucode = u;
        wr_kind = k; wr_idx = i; wr_data = d; wr_flip_par = f;
    endtask

    task automatic set_rd(input logic [TW-1:0] t, input logic [CW-1:0] c, input logic u,
                          input logic [1:0] ka, input logic [4:0] ia,
                          input logic [1:0] kb, input logic [4:0] ib);
        rd_tid = t; rd_cwp = c; rd_ucode = u;
        rd_kind_a = ka; rd_idx_a = ia; rd_kind_b = kb; rd_idx_b = ib;
    endtask

    task automatic wr(input logic [TW-1:0] t, input logic [CW-1:0] c, input logic u,
                      input logic [1:0] k, input logic [4:0] i, input logic [DW-1:0] d);
        set_wr(t, c, u, k, i, d, 1'b0);
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 data_a", rd_data_a, '0);
        chk("R11 data_b", rd_data_b, '0);
        chk("R11 flags", {27'd0, rd_perr_a, rd_perr_b, rd_fault_a, rd_fault_b, wr_reject}, '0);
    endtask

    task automatic t_globals_threads();
        wr(3'd2, 3'd0, 1'b0, KA, 5'd5, 32'hA5A5_0002);
        wr(3'd3, 3'd0, 1'b0, KA, 5'd5, 32'hB0B0_0003);
        wr(3'd7, 3'd0, 1'b0, KA, 5'd5, 32'h7777_0007);
        set_rd(3'd2, 3'd0, 1'b0, KA, 5'd5, KA, 5'd5);
        cyc();
        chk("R1 tid2 g5", rd_data_a, 32'hA5A5_0002);
        set_rd(3'd3, 3'd2, 1'b0, KA, 5'd5, KA, 5'd5);
        cyc();
        chk("R1 tid3 g5", rd_data_b, 32'hB0B0_0003);
        set_rd(3'd7, 3'd1, 1'b0, KA, 5'd5, KA, 5'd0);
        cyc();
        chk("R1 tid7 g5", rd_data_a, 32'h7777_0007);
        // R2: globals reachable from a rejected window pointer
        set_rd(3'd2, 3'd7, 1'b0, KA, 5'd5, KA, 5'd5);
        cyc();
        chk("R2 g5 cwp7", rd_data_a, 32'hA5A5_0002);
        chk("R2 no fault", {31'd0, rd_fault_a}, '0);
    endtask

    task automatic t_g0();
        wr(3'd1, 3'd0, 1'b0, KA, 5'd0, 32'hDEAD_BEEF);
        chk("R3 g0 write no reject", {31'd0, wr_reject}, '0);
        set_rd(3'd1, 3'd0, 1'b0, KA, 5'd0, KA, 5'd0);
        cyc();
        chk("R3 g0 reads zero", rd_data_a, '0);
        chk("R3 g0 flags", {30'd0, rd_perr_a, rd_fault_a}, '0);
    endtask

    task automatic t_tbr_scratch();
        wr(3'd4, 3'd0, 1'b0, KT, 5'd17, 32'h0000_4000);
        set_rd(3'd4, 3'd5, 1'b0, KT, 5'd0, KA, 5'd0);
        cyc();
        chk("R4 tbr read", rd_data_a, 32'h0000_4000);
        wr(3'd4, 3'd0, 1'b1, KS, 5'd3, 32'h5C5C_0003);
        set_rd(3'd4, 3'd0, 1'b1, KS, 5'd3, KT, 5'd9);
        cyc();
        chk("R5 scratch in ucode", rd_data_a, 32'h5C5C_0003);
        chk("R4 tbr not disturbed", rd_data_b, 32'h0000_4000);
        set_rd(3'd4, 3'd0, 1'b0, KS, 5'd3, KA, 5'd0);
        cyc();
        chk("R5 scratch outside ucode reads 0", rd_data_a, '0);
        chk("R5 scratch outside ucode faults", {31'd0, rd_fault_a}, 32'd1);
        set_wr(3'd4, 3'd0, 1'b0, KS, 5'd3, 32'h1111_1111, 1'b0);
        cyc();
        wr_en = 1'b0;
        chk("R5 write rejected", {31'd0, wr_reject}, 32'd1);
        set_rd(3'd4, 3'd0, 1'b1, KS, 5'd3, KS, 5'd0);
        cyc();
        chk("R5 scratch unchanged", rd_data_a, 32'h5C5C_0003);
        chk("R8 scratch 0 faults", {31'd0, rd_fault_b}, 32'd1);
        set_rd(3'd4, 3'd0, 1'b1, KR, 5'd1, KA, 5'd0);
        cyc();
        chk("R8 reserved kind faults", {31'd0, rd_fault_a}, 32'd1);
        set_wr(3'd4, 3'd0, 1'b1, KR, 5'd1, 32'h2222_2222, 1'b0);
        cyc();
        wr_en = 1'b0;
        chk("R8 reserved write rejected", {31'd0, wr_reject}, 32'd1);
        set_rd(3'd4, 3'd0, 1'b0, KT, 5'd0, KA, 5'd0);
        cyc();
        chk("R8 tbr intact after reserved write", rd_data_a, 32'h0000_4000);
    endtask

    task automatic t_windows();
        wr(3'd1, 3'd1, 1'b0, KA, 5'd16, 32'h1000_0016);
        wr(3'd1, 3'd1, 1'b0, KA, 5'd24, 32'h1000_0024);
        wr(3'd1, 3'd1, 1'b0, KA, 5'd8,  32'h1000_0008);
        wr(3'd1, 3'd2, 1'b0, KA, 5'd16, 32'h2000_0016);
        set_rd(3'd1, 3'd0, 1'b0, KA, 5'd24, KA, 5'd0);
        cyc();
        chk("R6 outs w1 are ins w0", rd_data_a, 32'h1000_0008);
        set_rd(3'd1, 3'd2, 1'b0, KA, 5'd8, KA, 5'd16);
        cyc();
        chk("R6 outs w2 are ins w1", rd_data_a, 32'h1000_0024);
        chk("R6 locals w2", rd_data_b, 32'h2000_0016);
        set_rd(3'd1, 3'd4, 1'b0, KA, 5'd16, KA, 5'd8);
        cyc();
        chk("R6 cwp4 maps to w1 locals", rd_data_a, 32'h1000_0016);
        chk("R6 cwp4 maps to w1 outs", rd_data_b, 32'h1000_0008);
    endtask

    task automatic t_cwp_limit();
        wr(3'd5, 3'd0, 1'b0, KA, 5'd9, 32'h0900_0000);
        set_wr(3'd5, 3'd6, 1'b0, KA, 5'd9, 32'hBAD0_0006, 1'b0);
        cyc();
        wr_en = 1'b0;
        chk("R7 write at cwp6 rejected", {31'd0, wr_reject}, 32'd1);
        set_rd(3'd5, 3'd0, 1'b0, KA, 5'd9, KA, 5'd0);
        cyc();
        chk("R7 storage unchanged", rd_data_a, 32'h0900_0000);
        set_rd(3'd5, 3'd6, 1'b0, KA, 5'd9, KA, 5'd20);
        cyc();
        chk("R7 read cwp6 zero", rd_data_a, '0);
        chk("R7 read cwp6 faults", {30'd0, rd_fault_a, rd_fault_b}, 32'd3);
    endtask

    task automatic t_timing();
        wr(3'd0, 3'd1, 1'b0, KA, 5'd21, 32'h0000_0021);
        wr(3'd0, 3'd1, 1'b0, KA, 5'd22, 32'h0000_0022);
        // same-cycle write then read of the same word
        set_wr(3'd0, 3'd1, 1'b0, KA, 5'd20, 32'hC0DE_0020, 1'b0);
        set_rd(3'd0, 3'd1, 1'b0, KA, 5'd20, KA, 5'd21);
        cyc();
        wr_en = 1'b0;
        chk("R9 write-first bypass", rd_data_a, 32'hC0DE_0020);
        chk("R9 other port", rd_data_b, 32'h0000_0021);
        // new request: unchanged after sample edge, updated after read edge
        set_rd(3'd0, 3'd1, 1'b0, KA, 5'd22, KA, 5'd22);
        @(posedge clk2x);
        #1;
        chk("R9 hold through sample half", rd_data_a, 32'hC0DE_0020);
        @(posedge clk2x);
        #1;
        chk("R9 update after read half", rd_data_a, 32'h0000_0022);
    endtask

    task automatic t_parity();
        set_wr(3'd6, 3'd0, 1'b0, KA, 5'd4, 32'h0F0F_1234, 1'b1);
        cyc();
        wr_en = 1'b0; wr_flip_par = 1'b0;
        set_rd(3'd6, 3'd0, 1'b0, KA, 5'd4, KA, 5'd4);
        cyc();
        chk("R10 perr A", {31'd0, rd_perr_a}, 32'd1);
        chk("R10 perr B", {31'd0, rd_perr_b}, 32'd1);
        chk("R10 data still returned", rd_data_a, 32'h0F0F_1234);
        wr(3'd6, 3'd0, 1'b0, KA, 5'd4, 32'h0F0F_1235);
        set_rd(3'd6, 3'd0, 1'b0, KA, 5'd4, KA, 5'd0);
        cyc();
        chk("R10 perr cleared", {30'd0, rd_perr_a, rd_perr_b}, '0);
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk2x);
        @(negedge clk2x);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_globals_threads();
        t_g0();
        t_tbr_scratch();
        t_windows();
        t_cwp_limit();
        t_timing();
        t_parity();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule